// File: doc/BRIEF.md
# SQE Heartbeat Test Generator

This block sits beside a transceiver's collision-reporting logic. It watches the station's transmit-activity level. When a frame has finished cleanly and the heartbeat option is on, it raises a request for a short burst of the 10 MHz collision tone. The station then sees that its collision path is alive. The request feeds the same tone driver that real collisions use. When the burst is over, the request falls and the collision pair goes back to idle.

A frame counts as clean only if no collision and no jabber was flagged at any clock edge while transmit was active. All timing is measured in bit times (BT, 100 ns). The BT tick comes from a divided fabric clock. With the default parameters that clock is 20 MHz, so one BT is two clocks. The gap before the burst and the burst length are parameters: 11 BT and 10 BT nominal. When transmit activity comes back while a test is pending or running, the test is dropped at once.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: A burst is requested only after a frame ends cleanly and `hb_enable` is high at the frame end. The frame end is the first rising clock edge that samples `tx_active` low after it was high.
- R2: `sqe_req` rises exactly `1 + CLKS_PER_BT*GAP_BT` clock edges after the frame-end edge. With the defaults this is 11.75 BT after `tx_active` drops, which lies inside the allowed 6 to 16 BT.
- R3: `sqe_req` stays high for exactly `CLKS_PER_BT*BURST_BT` clocks, which is 10 BT with the defaults. This lies inside the allowed 5 to 15 BT.
- R4: If `coll_seen` or `jabber_seen` is high at any edge where `tx_active` is high, the frame produces no burst. This includes the first and the last active edge.
- R5: If `tx_active` is high at an edge during the gap or the burst, `sqe_req` is low after that edge and the pending test is dropped.
- R6: After a burst, or when no test applies, `sqe_req` is low and stays low until the next qualifying frame end.
- R7: `coll_seen` and `jabber_seen` have no effect while `tx_active` is low. A test that is already pending still runs with its normal timing.
- R8: `hb_enable` is used only at the frame-end edge. Changes to it during the frame or during the gap do not change the outcome.
- R9: While `rst_n` is low at a clock edge, and after that edge, `sqe_req` is low and no test is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, `CLKS_PER_BT` cycles per bit time |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_active | input | 1 | High while the station transmits |
| hb_enable | input | 1 | Heartbeat test option; used at the frame end |
| coll_seen | input | 1 | Collision flagged during the current frame |
| jabber_seen | input | 1 | Jabber flagged during the current frame |
| sqe_req | output | 1 | Request to send the 10 MHz tone on the collision pair |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that a test only matters when `tx_active` stays low through the whole gap and burst. For that reason the length and gap checks are made only on bursts that no new activity cut short. The stimulus changes inputs only on the falling clock edge. It holds `hb_enable` at a chosen value at the frame-end edge. It raises collision and jabber flags either inside frames or in idle gaps, so both the suppression case and the ignore case occur. Random gaps are drawn either short enough to abort the test at a random point or long enough to let a full burst finish.

// File: rtl/sqe_pkg.sv
`timescale 1ns/1ps
// Shared types for the SQE heartbeat test generator.
package sqe_pkg;
    // Sequencer phases: waiting, counting the post-frame gap, presenting the tone
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_GAP   = 2'd1,
        SQ_BURST = 2'd2
    } sq_state_t;
endpackage

// File: rtl/sqe_bt_divider.sv
`timescale 1ns/1ps
// Bit-time tick divider.
// Gives a one-clock tick every CLKS_PER_BT clocks while run is high.
// Assumes restart is pulsed on the edge where the sequencer leaves idle,
// so each test measures its windows from a fixed phase.
module sqe_bt_divider #(
    parameter int CLKS_PER_BT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    generate
        if (CLKS_PER_BT <= 1) begin : g_direct
            // One clock per bit time: every running cycle is a tick
            assign tick = run;
        end else begin : g_count
            localparam int W = $clog2(CLKS_PER_BT);
            localparam logic [W-1:0] LAST = W'(CLKS_PER_BT - 1);
            logic [W-1:0] div_q;

            assign tick = run && (div_q == LAST);

            // Advance the phase counter; wrap on a tick, clear on restart
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (restart) begin
                    div_q <= '0;
                end else if (run) begin
                    div_q <= tick ? '0 : div_q + 1'b1;
                end
            end

            // Ticks are spaced by whole bit times, never back to back
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick repeated on consecutive clocks");
        end
    endgenerate
endmodule

// File: rtl/sqe_frame_qualifier.sv
`timescale 1ns/1ps
// Frame qualifier.
// Tracks one transmit frame and pulses end_ok for one clock when the frame
// ends with no collision or jabber seen while it was active and with the
// heartbeat option on at the end edge. Flags seen while idle are ignored.
module sqe_frame_qualifier (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic hb_enable,
    input  logic coll_seen,
    input  logic jabber_seen,
    output logic end_ok
);
    logic tx_q;
    logic fault_q;
    logic bad_now;

    assign bad_now = coll_seen || jabber_seen;

    // Remember last activity level to find the frame edges
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_active;
    end

    // Fault flag: reload on a frame start, set by any flag during the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (tx_active && !tx_q) begin
            fault_q <= bad_now;
        end else if (tx_active && bad_now) begin
            fault_q <= 1'b1;
        end
    end

    // Clean-end pulse on the edge that first sees activity gone
    always_ff @(posedge clk) begin
        if (!rst_n) end_ok <= 1'b0;
        else        end_ok <= tx_q && !tx_active && hb_enable && !fault_q;
    end

    // A frame end yields a single pulse
    p_end_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        end_ok |=> !end_ok)
        else $error("frame end pulse longer than one clock");
endmodule

// File: rtl/sqe_sequencer.sv
`timescale 1ns/1ps
// Heartbeat sequencer.
// After a clean-end pulse it waits GAP_BT ticks, then requests the tone for
// BURST_BT ticks, then returns to idle. Renewed transmit activity drops the
// test at the next edge. Assumes tick is a one-clock pulse per bit time.
module sqe_sequencer
    import sqe_pkg::*;
#(
    parameter int GAP_BT   = 11,
    parameter int BURST_BT = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      end_ok,
    input  logic      tx_active,
    input  logic      tick,
    output sq_state_t state,
    output logic      start,
    output logic      req
);
    localparam int MAXW = (GAP_BT > BURST_BT) ? GAP_BT : BURST_BT;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_BT - 1);
    localparam logic [CW-1:0] BURST_LAST = CW'(BURST_BT - 1);

    logic [CW-1:0] bt_cnt;

    assign start = (state == SQ_IDLE) && end_ok && !tx_active;
    assign req   = (state == SQ_BURST);

    // Phase and bit-time count advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            bt_cnt <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    bt_cnt <= '0;
                    if (start) state <= SQ_GAP;
                end
                SQ_GAP: begin
                    if (tx_active) begin
                        state  <= SQ_IDLE;
                        bt_cnt <= '0;
                    end else if (tick) begin
                        if (bt_cnt == GAP_LAST) begin
                            state  <= SQ_BURST;
                            bt_cnt <= '0;
                        end else begin
                            bt_cnt <= bt_cnt + 1'b1;
                        end
                    end
                end
                SQ_BURST: begin
                    if (tx_active) begin
                        state  <= SQ_IDLE;
                        bt_cnt <= '0;
                    end else if (tick) begin
                        if (bt_cnt == BURST_LAST) begin
                            state  <= SQ_IDLE;
                            bt_cnt <= '0;
                        end else begin
                            bt_cnt <= bt_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state  <= SQ_IDLE;
                    bt_cnt <= '0;
                end
            endcase
        end
    end

    // A gap is only entered from idle on a clean-end pulse
    p_gap_needs_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GAP && $past(state) == SQ_IDLE) |-> $past(end_ok))
        else $error("gap entered without a clean frame end");

    // The gap count never passes its window
    p_gap_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_GAP) |-> (bt_cnt <= GAP_LAST))
        else $error("gap counter out of range");

    // Only legal encodings are reached
    p_state_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {SQ_IDLE, SQ_GAP, SQ_BURST})
        else $error("illegal sequencer state");
endmodule

// File: rtl/sqe_heartbeat_gen.sv
`timescale 1ns/1ps
// SQE heartbeat test generator, top level.
// Joins the frame qualifier, the bit-time divider and the sequencer.
// Drives a request into the shared collision-tone driver.
// Assumes all inputs are synchronous to clk.
module sqe_heartbeat_gen
    import sqe_pkg::*;
#(
    parameter int CLKS_PER_BT = 2,
    parameter int GAP_BT      = 11,
    parameter int BURST_BT    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic hb_enable,
    input  logic coll_seen,
    input  logic jabber_seen,
    output logic sqe_req
);
    localparam int GAP_EDGES   = 1 + CLKS_PER_BT * GAP_BT;
    localparam int BURST_CLKS  = CLKS_PER_BT * BURST_BT;
    localparam int MW          = $clog2(GAP_EDGES + BURST_CLKS + 2);

    logic      end_ok;
    logic      tick;
    logic      start;
    sq_state_t state;

    sqe_frame_qualifier u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active   (tx_active),
        .hb_enable   (hb_enable),
        .coll_seen   (coll_seen),
        .jabber_seen (jabber_seen),
        .end_ok      (end_ok)
    );

    sqe_bt_divider #(.CLKS_PER_BT(CLKS_PER_BT)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (state != SQ_IDLE),
        .tick    (tick)
    );

    sqe_sequencer #(.GAP_BT(GAP_BT), .BURST_BT(BURST_BT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_ok    (end_ok),
        .tx_active (tx_active),
        .tick      (tick),
        .state     (state),
        .start     (start),
        .req       (sqe_req)
    );

    // ---------------- checking counters and assertions ----------------
    logic [MW-1:0] gap_meas;
    logic [MW-1:0] burst_meas;

    // Count edges from the clean-end pulse to the start of the burst
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap_meas <= '0;
        else if (tx_active || sqe_req)  gap_meas <= '0;
        else if (end_ok)                gap_meas <= MW'(1);
        else if (gap_meas != '0)        gap_meas <= gap_meas + 1'b1;
    end

    // Count clocks with the request high
    always_ff @(posedge clk) begin
        if (!rst_n)       burst_meas <= '0;
        else if (sqe_req) burst_meas <= burst_meas + 1'b1;
        else              burst_meas <= '0;
    end

    p_gap_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sqe_req) |-> (gap_meas == MW'(GAP_EDGES)))
        else $error("burst started at the wrong time");

    p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sqe_req |-> (burst_meas < MW'(BURST_CLKS)))
        else $error("burst too long");

    p_burst_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sqe_req) && !$past(tx_active)) |-> (burst_meas == MW'(BURST_CLKS)))
        else $error("burst ended early without new activity");

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !sqe_req)
        else $error("request high after renewed activity");
endmodule

// File: tb/sqe_heartbeat_gen_tb_top.sv
`timescale 1ns/1ps
module sqe_heartbeat_gen_tb_top;
    localparam int CPB = 2;
    localparam int GBT = 11;
    localparam int BBT = 10;
    localparam int RISE_K = 2 + CPB * GBT;
    localparam int LAST_K = 1 + CPB * (GBT + BBT);
    localparam int FULL_GAP = LAST_K + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic hb_enable = 1'b0;
    logic coll_seen = 1'b0;
    logic jabber_seen = 1'b0;
    logic sqe_req;

    int total = 0;
    int bad = 0;
    bit last_aborted = 1'b0;

    always #2.5 clk = ~clk;

    sqe_heartbeat_gen #(.CLKS_PER_BT(CPB), .GAP_BT(GBT), .BURST_BT(BBT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active   (tx_active),
        .hb_enable   (hb_enable),
        .coll_seen   (coll_seen),
        .jabber_seen (jabber_seen),
        .sqe_req     (sqe_req)
    );

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected request level k falling edges after activity dropped
    function automatic bit exp_req(input bit ok, input int k);
        return ok && (k >= RISE_K) && (k <= LAST_K);
    endfunction

    // Plays one frame followed by an idle gap of gap falling edges.
    // fault: 0 none, 1 collision, 2 jabber, raised at frame cycle fpos
    task automatic run_frame(input int len, input bit hb_end, input int fault,
                             input int fpos, input int gap, input bit noise);
        bit ok;
        int rise_k;
        int hi_cnt;
        ok = hb_end && (fault == 0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0)
                chk(sqe_req == 1'b0, last_aborted ? "R5 abort" : "R6 quiet", sqe_req, 0);
            tx_active   = 1'b1;
            hb_enable   = 1'($urandom_range(0, 1));
            coll_seen   = (fault == 1) && (i == fpos);
            jabber_seen = (fault == 2) && (i == fpos);
        end
        @(negedge clk);
        chk(sqe_req == 1'b0, "R6 quiet", sqe_req, 0);
        tx_active   = 1'b0;
        coll_seen   = 1'b0;
        jabber_seen = 1'b0;
        hb_enable   = hb_end;
        rise_k = 0;
        hi_cnt = 0;
        for (int k = 1; k <= gap; k++) begin
            @(negedge clk);
            chk(sqe_req == exp_req(ok, k),
                !ok ? (fault != 0 ? "R4 suppress" : "R1 heartbeat off") :
                (noise ? "R7 idle flags" : "R2/R3 window"),
                sqe_req, exp_req(ok, k));
            if (sqe_req && rise_k == 0) rise_k = k;
            if (sqe_req) hi_cnt++;
            hb_enable = 1'($urandom_range(0, 1));      // R8: ignored after the end edge
            if (noise) begin
                coll_seen   = 1'($urandom_range(0, 1));
                jabber_seen = 1'($urandom_range(0, 1));
            end
        end
        coll_seen   = 1'b0;
        jabber_seen = 1'b0;
        last_aborted = ok && (gap < FULL_GAP);
        if (ok && gap >= FULL_GAP) begin
            // R2: start in half-clocks after the drop must lie in 6..16 BT
            chk((2 * rise_k - 1) >= 6 * 2 * CPB && (2 * rise_k - 1) <= 16 * 2 * CPB,
                "R2 tolerance", 2 * rise_k - 1, RISE_K * 2 - 1);
            // R3: length must lie in 5..15 BT
            chk(hi_cnt >= 5 * CPB && hi_cnt <= 15 * CPB, "R3 tolerance", hi_cnt, CPB * BBT);
        end
    endtask

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R9: reset holds the request low, even with activity around
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i > 0) chk(sqe_req == 1'b0, "R9 reset", sqe_req, 0);
            tx_active = (i == 2);
            hb_enable = 1'b1;
        end
        @(negedge clk);
        chk(sqe_req == 1'b0, "R9 reset", sqe_req, 0);
        tx_active = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(sqe_req == 1'b0, "R9 after reset", sqe_req, 0);
        end

        // Directed cases
        run_frame(12, 1'b1, 0, 0, FULL_GAP + 3, 1'b0);   // R1 R2 R3 clean frame
        run_frame(1, 1'b1, 0, 0, FULL_GAP + 2, 1'b0);    // one-clock frame
        run_frame(8, 1'b1, 1, 0, FULL_GAP + 2, 1'b0);    // R4 collision on first edge
        run_frame(8, 1'b1, 2, 7, FULL_GAP + 2, 1'b0);    // R4 jabber on last edge
        run_frame(8, 1'b0, 0, 0, FULL_GAP + 2, 1'b0);    // R1 R8 heartbeat off at end
        run_frame(10, 1'b1, 0, 0, 10, 1'b0);             // R5 abort during gap
        run_frame(10, 1'b1, 0, 0, RISE_K, 1'b0);         // R5 abort on first burst clock
        run_frame(10, 1'b1, 0, 0, RISE_K + 7, 1'b0);     // R5 abort mid-burst
        run_frame(6, 1'b1, 0, 0, 1, 1'b0);               // R5 activity right after end
        run_frame(9, 1'b1, 0, 0, FULL_GAP + 4, 1'b1);    // R7 flags while idle

        // Random frames
        for (int n = 0; n < 60; n++) begin
            int len;
            int flt;
            int gap;
            bit hb;
            len = 1 + $urandom_range(0, 40);
            flt = $urandom_range(0, 3);
            if (flt > 2) flt = 0;
            hb  = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 2) == 0) gap = 1 + $urandom_range(0, LAST_K);
            else                           gap = FULL_GAP + $urandom_range(0, 15);
            run_frame(len, hb, flt, $urandom_range(0, len - 1), gap,
                      1'($urandom_range(0, 1)));
        end
        run_frame(5, 1'b1, 0, 0, FULL_GAP + 5, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule